// File: doc/BRIEF.md
# Coarse-Fine Multichannel Time Stamper

This block is the digital back end of a multichannel time-to-digital converter. A free-running counter on the reference clock gives the coarse part of every time stamp. Each channel also delivers a thermometer vector taken from a vernier or delay-line interpolator. The stop edge catches the start edge after k stages, and the number k becomes the fine part. The analog chain is not part of this block; its thermometer arrives as an ordinary input that is valid in the cycle of the channel's hit.

A hit is accepted only while the shared gate is high and the block is armed. A common start pulse arms the block and a common stop pulse disarms it. An accepted hit carries its thermometer and its coarse count through a short synchronization pipeline. The thermometer is then reduced to a binary code by counting its ones, and that code is joined below the coarse count. The result is parked in a per-channel pending slot. Pending slots drain into one shared event FIFO, lowest channel first, one entry per cycle. Each entry holds the time word and the channel index, and software or downstream logic reads it through a ready/valid port.

An event that cannot be stored is dropped and raises a sticky overflow flag. A one-cycle clear pulse lowers the flag again.

Top module: `tdc_stamper`

## Requirements
- R1: The coarse counter is 0 after reset and increments by one on every clock edge. It wraps from 2^COARSE_W-1 to 0, so the time word spans 2^(COARSE_W+FINE_W) fine units.
- R2: The event time word is {coarse, fine}. The coarse value is the counter value in the cycle the hit was sampled, and the fine code occupies the low FINE_W bits.
- R3: The fine code is the number of ones in the channel's 2^FINE_W-bit thermometer, with bubbles allowed. When every tap is set, the count exceeds 2^FINE_W-1 and saturates to that maximum. Channel c's thermometer occupies bits [c*2^FINE_W +: 2^FINE_W] of the flat input.
- R4: An accepted hit on a single channel with an empty FIFO appears on the read port, valid high, after the 4th rising edge counting the edge that sampled it (SYNC_STAGES+2 with the default of 2). It is not valid after edges 1 to 3.
- R5: A hit that is sampled while gate_en is low is discarded.
- R6: A start pulse arms the block from the next edge on, and a stop pulse disarms it; stop wins if both are high in the same cycle. Hits sampled while the block is not armed are discarded, including a hit in the same cycle as the start pulse.
- R7: Hits on several channels in the same cycle are written in ascending channel order, one per cycle. All of them carry the same time word, and ev_chan gives the channel index.
- R8: The read port shows the oldest entry while ev_valid is high. An entry leaves only on a cycle with ev_valid and ev_ready both high, and entries leave in write order.
- R9: An event that finds the FIFO full, with no read in the same cycle, or that finds its channel's pending slot still occupied, is dropped. The FIFO contents are left unchanged, and overflow is set.
- R10: overflow stays set until a cycle with ovf_clr high and no new drop; a drop in the same cycle wins over the clear.
- R11: After reset ev_valid and overflow are 0 and the block is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_start | input | 1 | Common start pulse, arms hit acceptance |
| arm_stop | input | 1 | Common stop pulse, disarms hit acceptance |
| gate_en | input | 1 | Common gate; hits are ignored while low |
| hit_i | input | NUM_CH | One-cycle hit strobe per channel |
| fine_therm_i | input | NUM_CH*2^FINE_W | Interpolator thermometer per channel, flat |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ev_ready | input | 1 | Consumer accepts the shown entry |
| ev_valid | output | 1 | An entry is shown on the read port |
| ev_time | output | COARSE_W+FINE_W | Time word {coarse, fine} of the shown entry |
| ev_chan | output | log2(NUM_CH) | Channel index of the shown entry |
| overflow | output | 1 | Sticky flag for dropped events |

## Verification
An accepted hit takes four rising edges, counting the edge that samples it, to reach the read port: two for synchronization, one into the pending slot and one into the FIFO. Simultaneous hits follow at one extra edge per channel. The bench drives every input just after a falling edge and counts rising edges from there. It checks that ev_valid is still low after the first three edges and high after the fourth, and it samples the time word at that falling edge. Discard, overflow and clear results are checked after waiting well past that latency, and each read is followed by one edge before the next entry is sampled.

// File: rtl/tdc_stamper_pkg.sv
package tdc_stamper_pkg;
  localparam int unsigned DEF_NUM_CH      = 8;
  localparam int unsigned DEF_FINE_W      = 4;
  localparam int unsigned DEF_COARSE_W    = 12;
  localparam int unsigned DEF_FIFO_DEPTH  = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tdc_hit_sync.sv
module tdc_hit_sync #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned TAPS        = 16,
  parameter int unsigned COARSE_W    = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH-1:0]            hit_q,
  input  logic [NUM_CH*TAPS-1:0]       therm_i,
  input  logic [COARSE_W-1:0]          coarse_i,
  output logic [NUM_CH-1:0]            sync_v,
  output logic [NUM_CH*TAPS-1:0]       sync_therm,
  output logic [NUM_CH*COARSE_W-1:0]   sync_coarse
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SYNC_STAGES-1:0] v_pipe;
    logic [TAPS-1:0]        t_pipe [SYNC_STAGES];
    logic [COARSE_W-1:0]    c_pipe [SYNC_STAGES];

    always_ff @(posedge clk) begin
      if (rst) begin
        v_pipe <= '0;
      end else begin
        v_pipe[0] <= hit_q[c];
        for (int s = 1; s < SYNC_STAGES; s++) v_pipe[s] <= v_pipe[s-1];
      end
    end

    always_ff @(posedge clk) begin
      t_pipe[0] <= therm_i[c*TAPS +: TAPS];
      c_pipe[0] <= coarse_i;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        t_pipe[s] <= t_pipe[s-1];
        c_pipe[s] <= c_pipe[s-1];
      end
    end

    assign sync_v[c]                           = v_pipe[SYNC_STAGES-1];
    assign sync_therm[c*TAPS +: TAPS]          = t_pipe[SYNC_STAGES-1];
    assign sync_coarse[c*COARSE_W +: COARSE_W] = c_pipe[SYNC_STAGES-1];
  end
endmodule

// File: rtl/tdc_therm_enc.sv
module tdc_therm_enc #(
  parameter int unsigned FINE_W = 4
) (
  input  logic [(1<<FINE_W)-1:0] therm,
  output logic [FINE_W-1:0]      code
);
  localparam int unsigned TAPS     = 1 << FINE_W;
  localparam int unsigned CODE_MAX = TAPS - 1;

  logic [FINE_W:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) ones = ones + (FINE_W+1)'(therm[i]);
    if (ones > (FINE_W+1)'(CODE_MAX)) code = FINE_W'(CODE_MAX);
    else                              code = ones[FINE_W-1:0];
  end
endmodule

// File: rtl/tdc_hit_arbiter.sv
module tdc_hit_arbiter #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned TIME_W = 16,
  parameter int unsigned CH_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          in_v,
  input  logic [NUM_CH*TIME_W-1:0]   in_time,
  output logic                       req,
  output logic [CH_W-1:0]            req_chan,
  output logic [TIME_W-1:0]          req_time,
  output logic                       collide
);
  logic [NUM_CH-1:0] pend_v;
  logic [NUM_CH-1:0] grant;
  logic [NUM_CH-1:0] load;
  logic [TIME_W-1:0] pend_t [NUM_CH];

  always_comb begin
    grant = '0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (pend_v[c]) grant = NUM_CH'(1) << c;
  end

  always_comb begin
    req_chan = '0;
    req_time = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (grant[c]) begin
        req_chan = CH_W'(c);
        req_time = pend_t[c];
      end
  end

  assign req     = |pend_v;
  assign load    = in_v & (~pend_v | grant);
  assign collide = |(in_v & pend_v & ~grant);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (load[c])       pend_v[c] <= 1'b1;
        else if (grant[c]) pend_v[c] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++)
      if (load[c]) pend_t[c] <= in_time[c*TIME_W +: TIME_W];
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R7
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
    req |-> ((pend_v & (grant - 1'b1)) == '0)); // R7
endmodule

// File: rtl/tdc_event_fifo.sv
module tdc_event_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             drop
);
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [ADDR_W:0]   count;
  logic              full, pop, push;

  assign full     = (count == (ADDR_W+1)'(DEPTH));
  assign rd_valid = (count != '0);
  assign pop      = rd_valid & rd_ready;
  assign push     = wr_req & (~full | pop);
  assign drop     = wr_req & full & ~pop;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req && !rd_ready) |=> (count == $past(count))); // R9
  AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && !wr_req) |=> (count == $past(count) - 1'b1)); // R8
endmodule

// File: rtl/tdc_stamper.sv
module tdc_stamper
  import tdc_stamper_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned FINE_W      = DEF_FINE_W,
  parameter int unsigned COARSE_W    = DEF_COARSE_W,
  parameter int unsigned FIFO_DEPTH  = DEF_FIFO_DEPTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  arm_start,
  input  logic                                  arm_stop,
  input  logic                                  gate_en,
  input  logic [NUM_CH-1:0]                     hit_i,
  input  logic [NUM_CH*(1<<FINE_W)-1:0]         fine_therm_i,
  input  logic                                  ovf_clr,
  input  logic                                  ev_ready,
  output logic                                  ev_valid,
  output logic [COARSE_W+FINE_W-1:0]            ev_time,
  output logic [idx_width(NUM_CH)-1:0]          ev_chan,
  output logic                                  overflow
);
  localparam int unsigned TAPS   = 1 << FINE_W;
  localparam int unsigned TIME_W = COARSE_W + FINE_W;
  localparam int unsigned CH_W   = idx_width(NUM_CH);
  localparam int unsigned EV_W   = CH_W + TIME_W;

  logic [COARSE_W-1:0]         coarse_q;
  logic                        armed;
  logic [NUM_CH-1:0]           hit_q;
  logic [NUM_CH-1:0]           sync_v;
  logic [NUM_CH*TAPS-1:0]      sync_therm;
  logic [NUM_CH*COARSE_W-1:0]  sync_coarse;
  logic [NUM_CH*TIME_W-1:0]    stamp;
  logic                        req, collide, fifo_drop, drop_any;
  logic [CH_W-1:0]             req_chan;
  logic [TIME_W-1:0]           req_time;
  logic [EV_W-1:0]             rd_data;

  always_ff @(posedge clk) begin
    if (rst) coarse_q <= '0;
    else     coarse_q <= coarse_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            armed <= 1'b0;
    else if (arm_stop)  armed <= 1'b0;
    else if (arm_start) armed <= 1'b1;
  end

  assign hit_q = hit_i & {NUM_CH{armed & gate_en}};

  tdc_hit_sync #(
    .NUM_CH(NUM_CH), .TAPS(TAPS), .COARSE_W(COARSE_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst(rst), .hit_q(hit_q), .therm_i(fine_therm_i), .coarse_i(coarse_q),
    .sync_v(sync_v), .sync_therm(sync_therm), .sync_coarse(sync_coarse)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_enc
    logic [FINE_W-1:0] fine_code;
    tdc_therm_enc #(.FINE_W(FINE_W)) u_enc (
      .therm(sync_therm[c*TAPS +: TAPS]),
      .code(fine_code)
    );
    assign stamp[c*TIME_W +: TIME_W] = {sync_coarse[c*COARSE_W +: COARSE_W], fine_code};
  end

  tdc_hit_arbiter #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .CH_W(CH_W)) u_arb (
    .clk(clk), .rst(rst), .in_v(sync_v), .in_time(stamp),
    .req(req), .req_chan(req_chan), .req_time(req_time), .collide(collide)
  );

  tdc_event_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(EV_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_req(req), .wr_data({req_chan, req_time}),
    .rd_ready(ev_ready), .rd_valid(ev_valid), .rd_data(rd_data), .drop(fifo_drop)
  );

  assign ev_chan  = rd_data[EV_W-1 -: CH_W];
  assign ev_time  = rd_data[TIME_W-1:0];
  assign drop_any = fifo_drop | collide;

  always_ff @(posedge clk) begin
    if (rst)           overflow <= 1'b0;
    else if (drop_any) overflow <= 1'b1;
    else if (ovf_clr)  overflow <= 1'b0;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clr) |=> overflow); // R10
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !drop_any) |=> !overflow); // R10
endmodule

// File: tb/test_tdc_stamper.sv
module test_tdc_stamper;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 8;
  localparam int FW    = 4;
  localparam int CW    = 12;
  localparam int TAPS  = 1 << FW;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm_start = 1'b0, arm_stop = 1'b0, gate_en = 1'b1, ovf_clr = 1'b0, ev_ready = 1'b0;
  logic [NCH-1:0]      hit_i = '0;
  logic [NCH*TAPS-1:0] fine_therm_i = '0;
  logic                ev_valid, overflow;
  logic [CW+FW-1:0]    ev_time;
  logic [2:0]          ev_chan;

  int checks = 0;
  int failures = 0;
  logic [CW-1:0] ref_coarse;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) ref_coarse <= '0;
    else     ref_coarse <= ref_coarse + 1'b1;
  end

  tdc_stamper i_tdc_stamper (
    .clk(clk), .rst(rst), .arm_start(arm_start), .arm_stop(arm_stop), .gate_en(gate_en),
    .hit_i(hit_i), .fine_therm_i(fine_therm_i), .ovf_clr(ovf_clr), .ev_ready(ev_ready),
    .ev_valid(ev_valid), .ev_time(ev_time), .ev_chan(ev_chan), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] fine_of(input logic [TAPS-1:0] t);
    int n = $countones(t);
    return (n > TAPS - 1) ? FW'(TAPS - 1) : FW'(n);
  endfunction

  // drive a one-cycle hit at the current falling edge; returns the coarse value sampled
  task automatic hit_pulse(input logic [NCH-1:0] mask, input logic [TAPS-1:0] th,
                           output logic [CW-1:0] cap);
    hit_i        = mask;
    fine_therm_i = {NCH{th}};
    cap          = ref_coarse;
    @(negedge clk);
    hit_i = '0;
  endtask

  task automatic pop_check(input string req, input logic [2:0] ch, input logic [CW+FW-1:0] tm);
    chk({req, " valid"}, 32'(ev_valid), 32'd1);
    chk({req, " chan"},  32'(ev_chan),  32'(ch));
    chk({req, " time"},  32'(ev_time),  32'(tm));
    ev_ready = 1'b1;
    @(negedge clk);
    ev_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 valid after reset", 32'(ev_valid), 32'd0);
    chk("R11 overflow after reset", 32'(overflow), 32'd0);
  endtask

  task automatic t_disarmed;
    logic [CW-1:0] cap;
    hit_pulse(8'h01, 16'h00FF, cap);
    repeat (8) @(negedge clk);
    chk("R11/R6 hit before start discarded", 32'(ev_valid), 32'd0);
  endtask

  task automatic t_arm;
    arm_start = 1'b1;
    @(negedge clk);
    arm_start = 1'b0;
  endtask

  task automatic t_latency;
    logic [CW-1:0] cap;
    hit_pulse(8'h08, 16'h00FF, cap);
    chk("R4 not valid after edge 1", 32'(ev_valid), 32'd0);
    @(negedge clk);
    chk("R4 not valid after edge 2", 32'(ev_valid), 32'd0);
    @(negedge clk);
    chk("R4 not valid after edge 3", 32'(ev_valid), 32'd0);
    @(negedge clk);
    pop_check("R4/R2 single hit", 3'd3, {cap, 4'd8});
    chk("R8 empty after pop", 32'(ev_valid), 32'd0);
  endtask

  task automatic t_encoder;
    logic [TAPS-1:0] pats [5];
    logic [CW-1:0] cap;
    pats[0] = 16'h0000;
    pats[1] = 16'h0001;
    pats[2] = 16'b0000_0101_1011_0111;
    pats[3] = 16'h7FFF;
    pats[4] = 16'hFFFF;
    for (int i = 0; i < 5; i++) begin
      hit_pulse(8'h20, pats[i], cap);
      repeat (3) @(negedge clk);
      pop_check("R3 thermometer code", 3'd5, {cap, fine_of(pats[i])});
    end
    chk("R3 saturated code is max", 32'(fine_of(16'hFFFF)), 32'd15);
  endtask

  task automatic t_gate;
    logic [CW-1:0] cap;
    gate_en = 1'b0;
    hit_pulse(8'hFF, 16'h000F, cap);
    gate_en = 1'b1;
    repeat (8) @(negedge clk);
    chk("R5 gated hit discarded", 32'(ev_valid), 32'd0);
  endtask

  task automatic t_multi;
    logic [CW-1:0] cap;
    hit_pulse(8'b0101_0010, 16'h0007, cap);
    repeat (8) @(negedge clk);
    pop_check("R7 first lowest channel", 3'd1, {cap, 4'd3});
    pop_check("R7 second channel", 3'd4, {cap, 4'd3});
    pop_check("R7 third channel", 3'd6, {cap, 4'd3});
    chk("R7 exactly three entries", 32'(ev_valid), 32'd0);
  endtask

  task automatic t_full;
    logic [CW-1:0] cap1, cap2, cap3;
    hit_pulse(8'hFF, 16'h0003, cap1);
    repeat (12) @(negedge clk);
    hit_pulse(8'hFF, 16'h003F, cap2);
    repeat (12) @(negedge clk);
    chk("R9 no overflow at exactly full", 32'(overflow), 32'd0);
    hit_pulse(8'h01, 16'h0001, cap3);
    repeat (10) @(negedge clk);
    chk("R9 overflow on full", 32'(overflow), 32'd1);
    for (int i = 0; i < 8; i++) pop_check("R8 order first burst", 3'(i), {cap1, 4'd2});
    for (int i = 0; i < 8; i++) pop_check("R9 order second burst", 3'(i), {cap2, 4'd6});
    chk("R9 dropped entry absent", 32'(ev_valid), 32'd0);
    chk("R10 overflow still set", 32'(overflow), 32'd1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R10 overflow cleared", 32'(overflow), 32'd0);
  endtask

  task automatic t_collision;
    logic [CW-1:0] c0, c1;
    hit_pulse(8'h03, 16'h0001, c0);
    hit_i = 8'h02; fine_therm_i = {NCH{16'h0003}}; c1 = ref_coarse;
    @(negedge clk);
    hit_i = 8'h00;
    hit_pulse(8'h02, 16'h0003, c1);
    repeat (10) @(negedge clk);
    chk("R9 collision sets overflow", 32'(overflow), 32'd1);
    pop_check("R9 collision ch0", 3'd0, {c0, 4'd1});
    pop_check("R9 collision ch1 kept", 3'd1, {c0, 4'd1});
    while (ev_valid) begin
      ev_ready = 1'b1; @(negedge clk); ev_ready = 1'b0;
    end
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  task automatic t_wrap;
    logic [CW-1:0] ca, cb;
    while (ref_coarse != {CW{1'b1}}) @(negedge clk);
    hit_pulse(8'h04, 16'h001F, ca);
    hit_pulse(8'h80, 16'h0000, cb);
    repeat (6) @(negedge clk);
    pop_check("R1 coarse at max", 3'd2, {12'hFFF, 4'd5});
    pop_check("R1 coarse wrapped to zero", 3'd7, {12'h000, 4'd0});
  endtask

  task automatic t_stop_start;
    logic [CW-1:0] cap;
    arm_stop = 1'b1;
    @(negedge clk);
    arm_stop = 1'b0;
    hit_pulse(8'h10, 16'h00FF, cap);
    repeat (8) @(negedge clk);
    chk("R6 hit after stop discarded", 32'(ev_valid), 32'd0);
    arm_start = 1'b1;
    hit_pulse(8'h10, 16'h00FF, cap);
    arm_start = 1'b0;
    repeat (8) @(negedge clk);
    chk("R6 hit with start pulse discarded", 32'(ev_valid), 32'd0);
    hit_pulse(8'h10, 16'h0FFF, cap);
    repeat (3) @(negedge clk);
    pop_check("R6 armed after start", 3'd4, {cap, 4'd12});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disarmed();
    t_arm();
    t_latency();
    t_encoder();
    t_gate();
    t_multi();
    t_full();
    t_collision();
    t_wrap();
    t_stop_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule